// File: doc/BRIEF.md
# DMA Page Translation Unit

This block maps the logical addresses issued by DMA engines onto physical memory addresses through a table of page entries. The logical address space is split into 4096-byte pages. The page number indexes a table of entries, and the byte offset within the page is carried across unchanged. Each entry is an 8-byte record. Its first 32-bit word holds the physical frame address of the page. Its second word is an owner tag that takes no part in translation. A frame word of zero marks the page as unmapped.

Software fills the table directly through a 32-bit table write port, addressed by byte offset into the table. Software also programs a table-base register and a table-limit register through a small register write port. The limit, divided by 8, sets how many entries are usable, up to the table capacity. A translation request carries one logical address. One clock later the block returns either the physical address with a valid flag, or a fault flag.

Top module: `dxl_unit`

## Requirements
- R1: After reset the table base and limit read as zero, every entry is disabled, and every request gets a fault.
- R2: For a mapped page, the physical address is the entry's frame word plus the low 12 bits of the logical address. It appears with the valid flag on the clock edge that follows the request.
- R3: A logical page index (address bits 31:12) equal to or above MAX_ENTRIES gets a fault, whatever the limit is.
- R4: The number of usable entries is the limit divided by 8, clamped to MAX_ENTRIES. A page index at or above that number gets a fault.
- R5: A limit below 8, including zero, disables translation, so every request gets a fault.
- R6: A request through an entry whose frame word is zero gets a fault. Writing zero to a frame word unmaps a page that was mapped before.
- R7: The table base output always has bit 31 cleared and bits 30:0 equal to the value last written (register select 0 = base, 1 = limit).
- R8: A write to the owner word of an entry leaves the mapping of that entry unchanged.
- R9: A frame-word write takes effect for a request presented on the next cycle.
- R10: The valid and fault flags are never high together. Neither is high unless a request was presented on the previous cycle.
- R11: The table write address is a byte offset. Bit 2 selects the word (0 = frame, 1 = owner), the bits above it give the entry index, and bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 1 | Register select: 0 base, 1 limit |
| reg_wr_data | input | ADDR_W | Register write data |
| tbl_wr_en | input | 1 | Table write strobe |
| tbl_wr_addr | input | TBL_AW | Byte offset into the table |
| tbl_wr_data | input | 32 | Table word write data |
| tbl_base | output | ADDR_W | Table base location, bit 31 cleared |
| tbl_limit | output | ADDR_W | Table limit register |
| req_valid | input | 1 | Translation request strobe |
| req_laddr | input | ADDR_W | Logical address of the request |
| rsp_valid | output | 1 | Translation succeeded |
| rsp_fault | output | 1 | Translation faulted |
| rsp_paddr | output | ADDR_W | Physical address, zero on a fault |

## Verification
The bench builds the block with MAX_ENTRIES set to 16, so the table write port is 7 bits wide. This puts the capacity clamp of the usable-entry count within reach of small limit values: 128 covers the whole table, and 8000 must clamp to 16. Page index 16 is the first index beyond capacity, so it can be tried directly. A partial limit of 24 also shows the cut-off falling inside the table.

// File: rtl/dxl_pkg.sv
package dxl_pkg;
   localparam int unsigned WORD_W     = 32;
   localparam int unsigned ENTRY_BYTES = 8;
   localparam int unsigned ENTRY_SHIFT = 3;
   typedef enum logic {
      SEL_BASE  = 1'b0,
      SEL_LIMIT = 1'b1
   } reg_sel_e;
endpackage

// File: rtl/dxl_regs.sv
module dxl_regs
   import dxl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned MAX_ENTRIES = 512,
   localparam int unsigned CNT_W      = $clog2(MAX_ENTRIES) + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic              sel,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] base_o,
   output logic [ADDR_W-1:0] limit_o,
   output logic [CNT_W-1:0]  usable_o
);
   localparam int unsigned LW_W = ADDR_W - ENTRY_SHIFT;
   localparam logic [LW_W-1:0] CAP = LW_W'(MAX_ENTRIES);

   logic [ADDR_W-1:0] base_q, limit_q;
   logic [LW_W-1:0]   lim_entries;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q  <= '0;
         limit_q <= '0;
      end else if (wr_en) begin
         if (reg_sel_e'(sel) == SEL_BASE)
            base_q <= {1'b0, wr_data[ADDR_W-2:0]};
         else
            limit_q <= wr_data;
      end
   end

   assign lim_entries = limit_q[ADDR_W-1:ENTRY_SHIFT];
   assign usable_o    = (lim_entries >= CAP) ? CNT_W'(MAX_ENTRIES)
                                             : lim_entries[CNT_W-1:0];
   assign base_o      = base_q;
   assign limit_o     = limit_q;

   // R7
   base_top_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      base_o[ADDR_W-1] == 1'b0);
endmodule

// File: rtl/dxl_table.sv
module dxl_table
   import dxl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned MAX_ENTRIES = 512,
   localparam int unsigned IDX_W      = $clog2(MAX_ENTRIES),
   localparam int unsigned TBL_AW     = IDX_W + ENTRY_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [TBL_AW-1:0] wr_addr,
   input  logic [WORD_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic              rd_valid,
   output logic [ADDR_W-1:0] rd_frame
);
   logic [ADDR_W-1:0]      frame_mem [MAX_ENTRIES];
   logic [MAX_ENTRIES-1:0] mapped_q;
   logic [IDX_W-1:0]       w_idx;
   logic                   w_frame;

   assign w_idx   = wr_addr[TBL_AW-1:ENTRY_SHIFT];
   assign w_frame = wr_en && (wr_addr[2] == 1'b0);

   always_ff @(posedge clk) begin
      if (w_frame) frame_mem[w_idx] <= ADDR_W'(wr_data);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       mapped_q <= '0;
      else if (w_frame) mapped_q[w_idx] <= |wr_data;
   end

   assign rd_valid = mapped_q[rd_idx];
   assign rd_frame = frame_mem[rd_idx];

   // R8
   owner_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[2]) |=> $stable(mapped_q));
endmodule

// File: rtl/dxl_lookup.sv
module dxl_lookup #(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PAGE_BITS   = 12,
   parameter int unsigned MAX_ENTRIES = 512,
   localparam int unsigned IDX_W      = $clog2(MAX_ENTRIES),
   localparam int unsigned CNT_W      = IDX_W + 1,
   localparam int unsigned PGN_W      = ADDR_W - PAGE_BITS
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_laddr,
   input  logic [CNT_W-1:0]  usable,
   output logic [IDX_W-1:0]  rd_idx,
   input  logic              rd_valid,
   input  logic [ADDR_W-1:0] rd_frame,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [ADDR_W-1:0] rsp_paddr
);
   logic [PGN_W-1:0]  page_no;
   logic              in_range, hit;
   logic [ADDR_W-1:0] paddr_d;

   assign page_no  = req_laddr[ADDR_W-1:PAGE_BITS];
   assign rd_idx   = page_no[IDX_W-1:0];
   assign in_range = page_no < PGN_W'(usable);
   assign hit      = in_range && rd_valid;
   assign paddr_d  = rd_frame + ADDR_W'(req_laddr[PAGE_BITS-1:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_fault <= 1'b0;
         rsp_paddr <= '0;
      end else begin
         rsp_valid <= req_valid && hit;
         rsp_fault <= req_valid && !hit;
         rsp_paddr <= (req_valid && hit) ? paddr_d : '0;
      end
   end

   // R10
   flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rsp_valid && rsp_fault));
   // R10
   reply_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid || rsp_fault) |-> $past(req_valid));
   // R5
   zero_usable_faults_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && usable == '0) |=> rsp_fault);
endmodule

// File: rtl/dxl_unit.sv
module dxl_unit
   import dxl_pkg::*;
#(
   parameter int unsigned ADDR_W      = 32,
   parameter int unsigned PAGE_BITS   = 12,
   parameter int unsigned MAX_ENTRIES = 512,
   localparam int unsigned IDX_W      = $clog2(MAX_ENTRIES),
   localparam int unsigned CNT_W      = IDX_W + 1,
   localparam int unsigned TBL_AW     = IDX_W + ENTRY_SHIFT
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr_en,
   input  logic              reg_sel,
   input  logic [ADDR_W-1:0] reg_wr_data,
   input  logic              tbl_wr_en,
   input  logic [TBL_AW-1:0] tbl_wr_addr,
   input  logic [31:0]       tbl_wr_data,
   output logic [ADDR_W-1:0] tbl_base,
   output logic [ADDR_W-1:0] tbl_limit,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_laddr,
   output logic              rsp_valid,
   output logic              rsp_fault,
   output logic [ADDR_W-1:0] rsp_paddr
);
   generate
      if (ADDR_W != WORD_W) begin : g_bad_width
         $error("ADDR_W must equal the 32-bit table word width");
      end
      if ((1 << IDX_W) != MAX_ENTRIES || MAX_ENTRIES < 2) begin : g_bad_depth
         $error("MAX_ENTRIES must be a power of two of at least 2");
      end
      if (ADDR_W - PAGE_BITS < CNT_W) begin : g_bad_page
         $error("page number field too narrow for the table depth");
      end
   endgenerate

   logic [CNT_W-1:0]  usable;
   logic [IDX_W-1:0]  rd_idx;
   logic              rd_valid;
   logic [ADDR_W-1:0] rd_frame;

   dxl_regs #(.ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_ENTRIES)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .sel(reg_sel),
      .wr_data(reg_wr_data), .base_o(tbl_base), .limit_o(tbl_limit),
      .usable_o(usable));

   dxl_table #(.ADDR_W(ADDR_W), .MAX_ENTRIES(MAX_ENTRIES)) table_i (
      .clk(clk), .rst_n(rst_n), .wr_en(tbl_wr_en), .wr_addr(tbl_wr_addr),
      .wr_data(tbl_wr_data), .rd_idx(rd_idx), .rd_valid(rd_valid),
      .rd_frame(rd_frame));

   dxl_lookup #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS),
                .MAX_ENTRIES(MAX_ENTRIES)) lookup_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_laddr(req_laddr),
      .usable(usable), .rd_idx(rd_idx), .rd_valid(rd_valid),
      .rd_frame(rd_frame), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .rsp_paddr(rsp_paddr));
endmodule

// File: tb/dxl_unit_tb_top.sv
module dxl_unit_tb_top;
   localparam int unsigned AW  = 32;
   localparam int unsigned ME  = 16;
   localparam int unsigned TAW = $clog2(ME) + 3;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           reg_wr_en = 1'b0, reg_sel = 1'b0;
   logic [AW-1:0]  reg_wr_data = '0;
   logic           tbl_wr_en = 1'b0;
   logic [TAW-1:0] tbl_wr_addr = '0;
   logic [31:0]    tbl_wr_data = '0;
   logic [AW-1:0]  tbl_base, tbl_limit;
   logic           req_valid = 1'b0;
   logic [AW-1:0]  req_laddr = '0;
   logic           rsp_valid, rsp_fault;
   logic [AW-1:0]  rsp_paddr;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   dxl_unit #(.MAX_ENTRIES(ME)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
      .reg_wr_data(reg_wr_data), .tbl_wr_en(tbl_wr_en),
      .tbl_wr_addr(tbl_wr_addr), .tbl_wr_data(tbl_wr_data),
      .tbl_base(tbl_base), .tbl_limit(tbl_limit), .req_valid(req_valid),
      .req_laddr(req_laddr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
      .rsp_paddr(rsp_paddr));

   // {logical address, expect fault, expected physical address}
   localparam logic [64:0] VEC [8] = '{
      {32'h0000_0123, 1'b0, 32'h0010_0123},   // R2 entry 0
      {32'h0000_1FFF, 1'b0, 32'h0ABC_DFFF},   // R2 entry 1, top offset
      {32'h0000_2000, 1'b1, 32'h0000_0000},   // R6 zero frame
      {32'h0000_3004, 1'b0, 32'h8000_0004},   // R2 high frame
      {32'h0000_F800, 1'b0, 32'h7FFF_F800},   // R2 last entry
      {32'h0001_0000, 1'b1, 32'h0000_0000},   // R3 index 16
      {32'hFFFF_F000, 1'b1, 32'h0000_0000},   // R3 far index
      {32'h0000_4ABC, 1'b1, 32'h0000_0000}    // R6 never written
   };

   task automatic check(input string req, input logic [AW-1:0] act,
                        input logic [AW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic sel, input logic [AW-1:0] d);
      @(negedge clk);
      reg_wr_en = 1'b1; reg_sel = sel; reg_wr_data = d;
      @(negedge clk);
      reg_wr_en = 1'b0;
   endtask

   task automatic wr_tbl(input logic [TAW-1:0] a, input logic [31:0] d);
      @(negedge clk);
      tbl_wr_en = 1'b1; tbl_wr_addr = a; tbl_wr_data = d;
      @(negedge clk);
      tbl_wr_en = 1'b0;
   endtask

   // request held over one edge; the reply is registered on that edge
   task automatic xlat(input string req, input logic [AW-1:0] la,
                       input logic exp_fault, input logic [AW-1:0] exp_pa);
      @(negedge clk);
      req_valid = 1'b1; req_laddr = la;
      @(negedge clk);
      req_valid = 1'b0;
      check(req, {30'd0, rsp_valid, rsp_fault}, {30'd0, !exp_fault, exp_fault});
      check(req, rsp_paddr, exp_pa);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures",
                  n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(20 * 20000);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check("R1", tbl_base, '0);
      check("R1", tbl_limit, '0);
      check("R1", {31'd0, rsp_valid | rsp_fault}, 32'd0);
      xlat("R1", 32'h0000_0010, 1'b1, '0);

      // fill table
      wr_tbl(7'h00, 32'h0010_0000);
      wr_tbl(7'h08, 32'h0ABC_D000);
      wr_tbl(7'h18, 32'h8000_0000);
      wr_tbl(7'h78, 32'h7FFF_F000);
      wr_tbl(7'h04, 32'h1234_5678);   // owner word only
      // R5 still zero limit: mapped entry faults
      xlat("R5", 32'h0000_0123, 1'b1, '0);
      wr_reg(1'b1, 32'd128);
      check("R4", tbl_limit, 32'd128);

      for (int i = 0; i < 8; i++)
         xlat("R2/R3/R6 vector", VEC[i][64:33], VEC[i][32], VEC[i][31:0]);

      // R8 owner write of entry 1 keeps mapping
      wr_tbl(7'h0C, 32'h0000_0000);
      xlat("R8", 32'h0000_1004, 1'b0, 32'h0ABC_D004);

      // R9 frame write takes effect on the next request
      wr_tbl(7'h10, 32'h0020_0000);
      xlat("R9", 32'h0000_2456, 1'b0, 32'h0020_0456);
      // R6 unmap a mapped page
      wr_tbl(7'h00, 32'h0000_0000);
      xlat("R6", 32'h0000_0123, 1'b1, '0);

      // R11 low byte bits ignored: offset 0x2B is entry 5 frame word
      wr_tbl(7'h2B, 32'h0030_0000);
      xlat("R11", 32'h0000_5777, 1'b0, 32'h0030_0777);
      // R11 bit 2 set: owner of entry 6, page stays unmapped
      wr_tbl(7'h34, 32'h0040_0000);
      xlat("R11", 32'h0000_6000, 1'b1, '0);

      // R4 partial limit: 3 usable entries
      wr_reg(1'b1, 32'd24);
      xlat("R4", 32'h0000_1010, 1'b0, 32'h0ABC_D010);
      xlat("R4", 32'h0000_3010, 1'b1, '0);
      // R4 clamp to capacity
      wr_reg(1'b1, 32'd8000);
      xlat("R4", 32'h0000_F001, 1'b0, 32'h7FFF_F001);
      xlat("R3", 32'h0001_0001, 1'b1, '0);
      // R5 limit below one entry
      wr_reg(1'b1, 32'd7);
      xlat("R5", 32'h0000_1010, 1'b1, '0);

      // R7 base masking
      wr_reg(1'b0, 32'hFFFF_FFF0);
      check("R7", tbl_base, 32'h7FFF_FFF0);
      check("R7", tbl_limit, 32'd7);
      wr_reg(1'b0, 32'h0001_2000);
      check("R7", tbl_base, 32'h0001_2000);

      // R10 no reply without a request
      @(negedge clk);
      check("R10", {30'd0, rsp_valid, rsp_fault}, 32'd0);

      // R1 reset clears a programmed unit
      wr_reg(1'b1, 32'd128);
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      check("R1", tbl_limit, '0);
      wr_reg(1'b1, 32'd128);
      xlat("R1", 32'h0000_F000, 1'b1, '0);

      finish_run();
   end
endmodule